// File: doc/BRIEF.md
# Shadow Return-Address Checker

This block keeps a second, hardware-owned copy of every return address so that a return whose address was tampered with in the program's own stack is caught. When the core retires a call, it hands the block the return address. The block pushes that address onto a private stack that the program cannot reach. When the core retires a return, it hands over the address the program actually popped. The block takes the top private entry, compares the two, and raises a sticky abort fault if they differ.

The eight most recent entries live in a small on-chip ring. A call that arrives with the ring full writes the oldest entry out through a private store port and stalls further events until the store acknowledges. A return that finds the ring empty while entries still sit in the store first reads the newest of them back, then compares. The store is addressed by a count of spilled entries. The store port carries only these spill writes and fill reads, so neither side of the private copy is exposed to general program access. Checking runs only while the enable input is high. Dropping the enable, or pulsing flush, discards all tracked entries.

Top module: `ret_guard`

## Requirements
- R1: While enabled, an accepted call (call_vld high with ready high) pushes call_ra. The matching returns, given in reverse order with the same addresses, raise neither fault at any nesting depth up to on-chip depth plus store depth.
- R2: An accepted return whose ret_ra differs from the tracked entry sets flt_abort. flt_abort stays high until flt_clr is asserted.
- R3: While chk_en is low, ready is high, call and return events change no state, no store request is issued, and neither fault is raised.
- R4: A call that arrives with all on-chip entries in use raises st_wr_req, with the oldest entry on st_wr_data and the current spill count on st_wr_idx (first spill at index 0). ready stays low until st_wr_ack.
- R5: A return that finds the ring empty and the spill count nonzero raises st_rd_req with st_rd_idx equal to the spill count minus one. ready stays low until st_rd_vld, and the returned st_rd_data is then compared as in R2.
- R6: A return with no entries on-chip and a zero spill count sets flt_under, which is held until flt_clr, and does not set flt_abort.
- R7: A flush pulse, or a low chk_en, empties the ring and zeroes the spill count, so the next return underflows.
- R8: A call and a return presented in the same cycle while enabled set flt_abort and neither push nor pop.
- R9: After reset, ready is high, both faults are low, and no store request is active.
- R10: A call that needs a spill while the store already holds its full capacity of entries sets flt_abort and issues no store write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Checking enable |
| flush | input | 1 | Discard all tracked entries |
| flt_clr | input | 1 | Clear both fault flags |
| call_vld | input | 1 | Call retired this cycle |
| call_ra | input | AW | Return address recorded by the call |
| ret_vld | input | 1 | Return retired this cycle |
| ret_ra | input | AW | Return address popped by the program |
| ready | output | 1 | Block can accept an event this cycle |
| flt_abort | output | 1 | Sticky mismatch / protocol / overflow fault |
| flt_under | output | 1 | Sticky underflow fault |
| st_wr_req | output | 1 | Spill write request |
| st_wr_idx | output | IXW | Spill slot index |
| st_wr_data | output | AW | Spilled return address |
| st_wr_ack | input | 1 | Spill write accepted |
| st_rd_req | output | 1 | Fill read request |
| st_rd_idx | output | IXW | Fill slot index |
| st_rd_vld | input | 1 | Fill data valid |
| st_rd_data | input | AW | Filled return address |

## Verification
The case that is hardest to reach from the ports is a wrong address that has to be fetched back from the store after it has travelled out through a spill. It needs a nesting deeper than the ring, a spill order that puts each address at the right index, and a fill that reads the right index back. The bench gets there by sweeping the nesting depth across the whole ring-plus-store range, using a small store. It then injects a single wrong return address at each position of a twelve-deep nest, so that the bad return lands both on ring entries and on filled entries. A bench-side store model answers both handshakes, and its contents are compared with the addresses each spill should carry.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } rg_state_e;
endpackage

// File: rtl/ret_guard_lifo.sv
module ret_guard_lifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] top_data,
  output logic [AW-1:0] old_data,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot [DEPTH];
  logic [IW-1:0] top_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] ring_inc(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + IW'(1);
  endfunction

  function automatic logic [IW-1:0] ring_dec(input logic [IW-1:0] i);
    return (i == '0) ? IW'(DEPTH - 1) : i - IW'(1);
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign top_data = slot[ring_dec(top_q)];
  // When the ring is full the write position is also the oldest entry.
  assign old_data = slot[top_q];

  always_ff @(posedge clk) begin
    if (push) slot[top_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      top_q <= ring_inc(top_q);
      if (!full) cnt_q <= cnt_q + CW'(1);
    end else if (pop) begin
      top_q <= ring_dec(top_q);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_no_dual_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/ret_guard_seq.sv
module ret_guard_seq
  import ret_guard_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BS_DEPTH = 64,
  parameter int IXW      = (BS_DEPTH > 1) ? $clog2(BS_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chk_en,
  input  logic           flush,
  input  logic           call_vld,
  input  logic [AW-1:0]  call_ra,
  input  logic           ret_vld,
  input  logic [AW-1:0]  ret_ra,
  output logic           ready,
  input  logic           ring_full,
  input  logic           ring_empty,
  input  logic [AW-1:0]  ring_top,
  input  logic [AW-1:0]  ring_old,
  output logic           ring_push,
  output logic           ring_pop,
  output logic           ring_clear,
  output logic [AW-1:0]  ring_wdata,
  output logic           st_wr_req,
  output logic [IXW-1:0] st_wr_idx,
  output logic [AW-1:0]  st_wr_data,
  input  logic           st_wr_ack,
  output logic           st_rd_req,
  output logic [IXW-1:0] st_rd_idx,
  input  logic           st_rd_vld,
  input  logic [AW-1:0]  st_rd_data,
  output logic           ev_mismatch,
  output logic           ev_underflow,
  output logic           ev_proto,
  output logic           ev_overflow
);
  localparam int SW = $clog2(BS_DEPTH + 1);

  rg_state_e     st_q;
  logic [SW-1:0] scnt_q;
  logic [AW-1:0] spill_q;
  logic [AW-1:0] want_q;

  function automatic logic [IXW-1:0] newest_slot(input logic [SW-1:0] c);
    logic [SW-1:0] t;
    t = c - SW'(1);
    return t[IXW-1:0];
  endfunction

  function automatic logic [IXW-1:0] next_slot(input logic [SW-1:0] c);
    return c[IXW-1:0];
  endfunction

  logic active, acc_call, acc_ret;
  logic spill_need, spill_room, need_fill, fill_done;
  logic ring_bad, fill_bad;

  assign active     = chk_en && !flush;
  assign ready      = (st_q == ST_IDLE);
  assign acc_call   = active && ready && call_vld && !ret_vld;
  assign acc_ret    = active && ready && ret_vld && !call_vld;
  assign ev_proto   = active && ready && call_vld && ret_vld;

  assign spill_need = acc_call && ring_full;
  assign spill_room = (scnt_q < SW'(BS_DEPTH));
  assign ev_overflow = spill_need && !spill_room;

  assign ring_clear = !active;
  assign ring_push  = acc_call;
  assign ring_wdata = call_ra;
  assign ring_pop   = acc_ret && !ring_empty;
  assign ring_bad   = ring_pop && (ring_top != ret_ra);

  assign need_fill    = acc_ret && ring_empty && (scnt_q != '0);
  assign ev_underflow = acc_ret && ring_empty && (scnt_q == '0);
  assign fill_done    = (st_q == ST_FILL) && st_rd_vld;
  assign fill_bad     = fill_done && (st_rd_data != want_q);
  assign ev_mismatch  = ring_bad || fill_bad;

  assign st_wr_req  = (st_q == ST_SPILL);
  assign st_wr_idx  = next_slot(scnt_q);
  assign st_wr_data = spill_q;
  assign st_rd_req  = (st_q == ST_FILL);
  assign st_rd_idx  = newest_slot(scnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      st_q   <= ST_IDLE;
      scnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (spill_need && spill_room) st_q <= ST_SPILL;
          else if (need_fill)           st_q <= ST_FILL;
        end
        ST_SPILL: begin
          if (st_wr_ack) begin
            st_q   <= ST_IDLE;
            scnt_q <= scnt_q + SW'(1);
          end
        end
        ST_FILL: begin
          if (st_rd_vld) begin
            st_q   <= ST_IDLE;
            scnt_q <= scnt_q - SW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (spill_need) spill_q <= ring_old;
    if (need_fill)  want_q  <= ret_ra;
  end

  p_spill_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_req |-> !ready);
  p_spill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_req && !st_wr_ack |=> st_wr_req && $stable(st_wr_data));
  p_fill_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_req |-> !ready);
  p_fill_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active && st_rd_req && st_rd_vld |=> scnt_q == $past(scnt_q) - SW'(1));
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !st_wr_req && !st_rd_req && scnt_q == '0);
  p_under_nopop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |-> !ring_pop && !need_fill);
  p_store_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scnt_q <= SW'(BS_DEPTH));
endmodule

// File: rtl/ret_guard_flags.sv
module ret_guard_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_clr,
  input  logic ev_mismatch,
  input  logic ev_proto,
  input  logic ev_overflow,
  input  logic ev_underflow,
  output logic flt_abort,
  output logic flt_under
);
  logic abort_set;
  assign abort_set = ev_mismatch || ev_proto || ev_overflow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_abort <= 1'b0;
      flt_under <= 1'b0;
    end else begin
      if (abort_set)    flt_abort <= 1'b1;
      else if (flt_clr) flt_abort <= 1'b0;
      if (ev_underflow) flt_under <= 1'b1;
      else if (flt_clr) flt_under <= 1'b0;
    end
  end

  p_abort_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_abort && !flt_clr |=> flt_abort);
  p_mismatch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> flt_abort);
  p_under_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> flt_under);
  p_proto_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proto |=> flt_abort);
  p_over_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> flt_abort);
endmodule

// File: rtl/ret_guard.sv
module ret_guard #(
  parameter int AW       = 32,
  parameter int DEPTH    = 8,
  parameter int BS_DEPTH = 64,
  parameter int IXW      = (BS_DEPTH > 1) ? $clog2(BS_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chk_en,
  input  logic           flush,
  input  logic           flt_clr,
  input  logic           call_vld,
  input  logic [AW-1:0]  call_ra,
  input  logic           ret_vld,
  input  logic [AW-1:0]  ret_ra,
  output logic           ready,
  output logic           flt_abort,
  output logic           flt_under,
  output logic           st_wr_req,
  output logic [IXW-1:0] st_wr_idx,
  output logic [AW-1:0]  st_wr_data,
  input  logic           st_wr_ack,
  output logic           st_rd_req,
  output logic [IXW-1:0] st_rd_idx,
  input  logic           st_rd_vld,
  input  logic [AW-1:0]  st_rd_data
);
  logic          ring_full, ring_empty, ring_push, ring_pop, ring_clear;
  logic [AW-1:0] ring_top, ring_old, ring_wdata;
  logic          ev_mismatch, ev_underflow, ev_proto, ev_overflow;

  ret_guard_lifo #(.AW(AW), .DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ring_clear),
    .push     (ring_push),
    .pop      (ring_pop),
    .wdata    (ring_wdata),
    .top_data (ring_top),
    .old_data (ring_old),
    .full     (ring_full),
    .empty    (ring_empty)
  );

  ret_guard_seq #(.AW(AW), .BS_DEPTH(BS_DEPTH), .IXW(IXW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en       (chk_en),
    .flush        (flush),
    .call_vld     (call_vld),
    .call_ra      (call_ra),
    .ret_vld      (ret_vld),
    .ret_ra       (ret_ra),
    .ready        (ready),
    .ring_full    (ring_full),
    .ring_empty   (ring_empty),
    .ring_top     (ring_top),
    .ring_old     (ring_old),
    .ring_push    (ring_push),
    .ring_pop     (ring_pop),
    .ring_clear   (ring_clear),
    .ring_wdata   (ring_wdata),
    .st_wr_req    (st_wr_req),
    .st_wr_idx    (st_wr_idx),
    .st_wr_data   (st_wr_data),
    .st_wr_ack    (st_wr_ack),
    .st_rd_req    (st_rd_req),
    .st_rd_idx    (st_rd_idx),
    .st_rd_vld    (st_rd_vld),
    .st_rd_data   (st_rd_data),
    .ev_mismatch  (ev_mismatch),
    .ev_underflow (ev_underflow),
    .ev_proto     (ev_proto),
    .ev_overflow  (ev_overflow)
  );

  ret_guard_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_clr      (flt_clr),
    .ev_mismatch  (ev_mismatch),
    .ev_proto     (ev_proto),
    .ev_overflow  (ev_overflow),
    .ev_underflow (ev_underflow),
    .flt_abort    (flt_abort),
    .flt_under    (flt_under)
  );

  p_one_store_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_wr_req && st_rd_req));
endmodule

// File: tb/ret_guard_tb.sv
module ret_guard_tb;
  localparam int AW = 16;
  localparam int DP = 8;
  localparam int BS = 4;
  localparam int IXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, flush = 1'b0, flt_clr = 1'b0;
  logic call_vld = 1'b0, ret_vld = 1'b0;
  logic [AW-1:0] call_ra = '0, ret_ra = '0;
  logic ready, flt_abort, flt_under, st_wr_req, st_rd_req;
  logic [IXW-1:0] st_wr_idx, st_rd_idx;
  logic [AW-1:0] st_wr_data;
  logic st_wr_ack = 1'b0, st_rd_vld = 1'b0;
  logic [AW-1:0] st_rd_data = '0;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] store [16];

  always #4 clk = ~clk;

  ret_guard #(.AW(AW), .DEPTH(DP), .BS_DEPTH(BS), .IXW(IXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .flush(flush), .flt_clr(flt_clr),
    .call_vld(call_vld), .call_ra(call_ra), .ret_vld(ret_vld), .ret_ra(ret_ra),
    .ready(ready), .flt_abort(flt_abort), .flt_under(flt_under),
    .st_wr_req(st_wr_req), .st_wr_idx(st_wr_idx), .st_wr_data(st_wr_data),
    .st_wr_ack(st_wr_ack), .st_rd_req(st_rd_req), .st_rd_idx(st_rd_idx),
    .st_rd_vld(st_rd_vld), .st_rd_data(st_rd_data)
  );

  // Store model: answers each request one half-cycle after it appears.
  initial begin
    forever begin
      @(negedge clk);
      if (st_wr_req && !st_wr_ack) begin
        store[{2'b00, st_wr_idx}] = st_wr_data;
        wr_cnt = wr_cnt + 1;
        st_wr_ack = 1'b1;
      end else st_wr_ack = 1'b0;
      if (st_rd_req && !st_rd_vld) begin
        st_rd_data = store[{2'b00, st_rd_idx}];
        rd_cnt = rd_cnt + 1;
        st_rd_vld = 1'b1;
      end else st_rd_vld = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(input int n, input int i);
    return AW'(16'h4000 + n * 256 + i * 37);
  endfunction

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_call(input logic [AW-1:0] a);
    wait_ready();
    call_vld = 1'b1; call_ra = a;
    @(negedge clk);
    call_vld = 1'b0;
    wait_ready();
  endtask

  task automatic do_ret(input logic [AW-1:0] a);
    wait_ready();
    ret_vld = 1'b1; ret_ra = a;
    @(negedge clk);
    ret_vld = 1'b0;
    wait_ready();
  endtask

  task automatic scrub();
    flush = 1'b1; flt_clr = 1'b1;
    @(negedge clk);
    flush = 1'b0; flt_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: reset state
    check("R9 ready", int'(ready), 1);
    check("R9 abort", int'(flt_abort), 0);
    check("R9 under", int'(flt_under), 0);
    check("R9 wreq", int'(st_wr_req), 0);
    check("R9 rreq", int'(st_rd_req), 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    @(negedge clk);

    // R1 R4 R5: depth sweep across ring plus store
    for (int n = 1; n <= DP + BS; n++) begin
      int w0, r0, sp;
      scrub();
      w0 = wr_cnt; r0 = rd_cnt;
      sp = (n > DP) ? n - DP : 0;
      for (int i = 0; i < n; i++) do_call(ra(n, i));
      check("R4 spill count", wr_cnt - w0, sp);
      for (int j = 0; j < sp; j++) check("R4 spilled oldest", int'(store[j]), int'(ra(n, j)));
      for (int i = n - 1; i >= 0; i--) do_ret(ra(n, i));
      check("R5 fill count", rd_cnt - r0, sp);
      check("R1 no abort", int'(flt_abort), 0);
      check("R1 no under", int'(flt_under), 0);
    end

    // R2 R5: one wrong return at each position of a 12-deep nest
    for (int k = 0; k < DP + BS; k++) begin
      scrub();
      for (int i = 0; i < DP + BS; i++) do_call(ra(50, i));
      for (int j = 0; j < DP + BS; j++) begin
        int idx;
        idx = DP + BS - 1 - j;
        do_ret((j == k) ? ra(50, idx) ^ AW'(16'h0100) : ra(50, idx));
        check((j >= DP) ? "R5 fill compare" : "R2 ring compare",
              int'(flt_abort), (j >= k) ? 1 : 0);
      end
      check("R2 no under", int'(flt_under), 0);
    end
    scrub();
    check("R2 cleared", int'(flt_abort), 0);

    // R6: underflow on empty
    do_ret(16'h1234);
    check("R6 under", int'(flt_under), 1);
    check("R6 no abort", int'(flt_abort), 0);
    scrub();
    check("R6 cleared", int'(flt_under), 0);

    // R3: disabled events are ignored
    chk_en = 1'b0;
    @(negedge clk);
    begin
      int w0;
      w0 = wr_cnt;
      for (int i = 0; i < DP + 2; i++) do_call(ra(70, i));
      do_ret(16'hdead);
      check("R3 ready", int'(ready), 1);
      check("R3 abort", int'(flt_abort), 0);
      check("R3 under", int'(flt_under), 0);
      check("R3 no spill", wr_cnt - w0, 0);
    end
    chk_en = 1'b1;
    @(negedge clk);
    do_ret(ra(70, 0));
    check("R3 nothing tracked", int'(flt_under), 1);
    scrub();

    // R7: flush empties tracked entries
    for (int i = 0; i < DP + 2; i++) do_call(ra(80, i));
    flush = 1'b1; @(negedge clk); flush = 1'b0; @(negedge clk);
    do_ret(ra(80, DP + 1));
    check("R7 flush under", int'(flt_under), 1);
    check("R7 flush abort", int'(flt_abort), 0);
    scrub();
    // R7: enable drop empties tracked entries
    for (int i = 0; i < 3; i++) do_call(ra(81, i));
    chk_en = 1'b0; @(negedge clk); chk_en = 1'b1; @(negedge clk);
    do_ret(ra(81, 2));
    check("R7 enable drop under", int'(flt_under), 1);
    scrub();

    // R8: simultaneous call and return
    do_call(ra(90, 0));
    call_vld = 1'b1; call_ra = ra(90, 1);
    ret_vld = 1'b1; ret_ra = ra(90, 7);
    @(negedge clk);
    call_vld = 1'b0; ret_vld = 1'b0;
    check("R8 abort", int'(flt_abort), 1);
    do_ret(ra(90, 0));
    check("R8 stack intact", int'(flt_under), 0);
    do_ret(ra(90, 0));
    check("R8 no push", int'(flt_under), 1);
    scrub();

    // R10: store exhausted
    begin
      int w0;
      w0 = wr_cnt;
      for (int i = 0; i < DP + BS; i++) do_call(ra(95, i));
      check("R10 full no fault", int'(flt_abort), 0);
      do_call(ra(95, DP + BS));
      check("R10 overflow abort", int'(flt_abort), 1);
      check("R10 no extra write", wr_cnt - w0, BS);
    end
    scrub();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule